// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into an asynchronous serial bit stream on a single output line. An external enable, `baud_tick`, sets the rate. Each bit lasts a fixed number of ticks: 16 in normal mode and 8 in double-speed mode. A one-entry holding buffer sits in front of the shift register. Software can therefore write the next character while the current one is still on the line, and the next frame then starts with no idle gap. The frame format is set at run time through plain ports:

- 5 to 9 data bits;
- optional even or odd parity;
- one or two stop bits.

The format is captured when a character moves from the buffer into the shift register.

Two status outputs tell the writer what to do next. `buf_empty` means a new character may be written. `tx_done` means the line has gone quiet after the last frame. The transmitter runs on its own and has no dependency on any receiver.

The sequencer has five states:

| State | Line level | Leaves when | Goes to |
|---|---|---|---|
| `ST_IDLE` | high | the buffer holds a character (a load) | `ST_START` |
| `ST_START` | low | the bit time ends | `ST_DATA` |
| `ST_DATA` | least significant bit first | the bit time of the last data bit ends | `ST_PARITY` if parity is enabled, otherwise `ST_STOP` |
| `ST_PARITY` | the parity bit | the bit time ends | `ST_STOP` |
| `ST_STOP` | high | the bit time of the last stop bit ends | `ST_START` if the buffer is full (a load), otherwise `ST_IDLE` with `tx_done` set |

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame has these bits in this order:
  - a start bit at 0;
  - the data bits, least significant first;
  - the parity bit, if parity is enabled;
  - the stop bits at 1.
- R3: `data_bits` code 0, 1, 2, 3 or 4 selects 5, 6, 7, 8 or 9 data bits (codes 5 to 7 select 9). Bits of `wr_data` above the selected length are not sent.
- R4: When `parity_en` is 1, a parity bit follows the data. With `parity_odd` at 0 it is the XOR of the sent data bits (even parity). With `parity_odd` at 1 it is the inverse of that XOR (odd parity).
- R5: `two_stop` at 1 sends two stop bits; at 0 it sends one.
- R6: A write accepted while the buffer is empty drives `buf_empty` low after that clock edge. `buf_empty` goes high again at the edge where the character moves into the shift register, which is the edge where the start bit begins.
- R7: `tx_done` rises at the edge that ends the final stop bit, but only when the buffer is empty then. An accepted write clears it.
- R8: Each bit lasts 16 `baud_tick` pulses with `double_speed` at 0 and 8 pulses with `double_speed` at 1.
- R9: A character already waiting when the final stop bit ends starts its start bit at that same edge, and `tx_done` stays 0 between the two frames.
- R10: A write while the buffer is full is ignored. The held character is still the one sent, and `buf_empty` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle rate enable, 16 or 8 per bit |
| double_speed | input | 1 | 1 selects 8 ticks per bit |
| data_bits | input | 3 | Data length code (length = code + 5, at most 9) |
| parity_en | input | 1 | Insert a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | MAX_BITS | Character to send |
| tx_line | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can take a character |
| tx_done | output | 1 | Last frame finished and no character is waiting |

## Verification
The assertions assume the following about the inputs:
- reset is applied before the first frame;
- `double_speed` does not change during a frame, because the bit timer reads it live while the other format inputs are captured at load.

The directed bench changes the format and speed inputs only while the line is idle and `tx_done` is high. It issues `baud_tick` as a single-cycle pulse every third clock. It writes only on the falling clock edge, so the strobe is always stable around the sampling edge.

// File: rtl/tx_pkg.sv
package tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_t;

    localparam int MIN_BITS = 5;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic baud_tick,
    input  logic double_speed,
    output logic bit_end
);
    localparam int CW = $clog2(OVERSAMPLE);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        last_cnt = double_speed ? CW'(OVERSAMPLE / 2 - 1) : CW'(OVERSAMPLE - 1);
        bit_end  = run && baud_tick && (cnt_q == last_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (baud_tick) begin
            if (bit_end) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [MAX_BITS-1:0] wr_data,
    input  logic                take,
    output logic                accept,
    output logic                full,
    output logic [MAX_BITS-1:0] data
);
    assign accept = wr_en && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (take)   full <= 1'b0;
            if (accept) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import tx_pkg::*;
#(
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                buf_full,
    input  logic [MAX_BITS-1:0] buf_data,
    input  logic [2:0]          bits_code,
    input  logic                parity_en,
    input  logic                parity_odd,
    input  logic                two_stop,
    input  logic                bit_end,
    input  logic                wr_accept,
    output logic                load,
    output tx_state_t           state,
    output logic                tx_line,
    output logic                tx_done
);
    localparam int NW = $clog2(MAX_BITS + 1);

    tx_state_t           state_q, state_d;
    logic [MAX_BITS-1:0] shift_q;
    logic [NW-1:0]       nbits_q, idx_q, want_bits;
    logic                par_en_q, two_q, par_q, stop_cnt_q;
    logic                par_calc, finish, last_data, last_stop;

    always_comb begin
        if (32'(bits_code) + MIN_BITS > MAX_BITS) want_bits = NW'(MAX_BITS);
        else                                      want_bits = NW'(32'(bits_code) + MIN_BITS);
        par_calc = parity_odd;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (i < int'(want_bits)) par_calc = par_calc ^ buf_data[i];
        end
    end

    assign last_data = (idx_q == nbits_q - 1'b1);
    assign last_stop = !two_q || stop_cnt_q;

    // Next-state and load decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (buf_full) begin
                    load    = 1'b1;
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && last_data) state_d = par_en_q ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (bit_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_end && last_stop) begin
                    if (buf_full) begin
                        load    = 1'b1;
                        state_d = ST_START;
                    end else begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            shift_q    <= '0;
            nbits_q    <= NW'(MAX_BITS);
            idx_q      <= '0;
            par_en_q   <= 1'b0;
            two_q      <= 1'b0;
            par_q      <= 1'b0;
            stop_cnt_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                shift_q    <= buf_data;
                nbits_q    <= want_bits;
                par_en_q   <= parity_en;
                two_q      <= two_stop;
                par_q      <= par_calc;
                idx_q      <= '0;
                stop_cnt_q <= 1'b0;
            end else if (bit_end) begin
                if (state_q == ST_DATA) begin
                    shift_q <= shift_q >> 1;
                    idx_q   <= idx_q + 1'b1;
                end
                if (state_q == ST_STOP) stop_cnt_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = shift_q[0];
            ST_PARITY: tx_line = par_q;
            default:   tx_line = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tx_done <= 1'b0;
        else if (wr_accept) tx_done <= 1'b0;
        else if (finish)    tx_done <= 1'b1;
    end

    assign state = state_q;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import tx_pkg::*;
#(
    parameter int MAX_BITS   = 9,
    parameter int OVERSAMPLE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                double_speed,
    input  logic [2:0]          data_bits,
    input  logic                parity_en,
    input  logic                parity_odd,
    input  logic                two_stop,
    input  logic                wr_en,
    input  logic [MAX_BITS-1:0] wr_data,
    output logic                tx_line,
    output logic                buf_empty,
    output logic                tx_done
);
    logic                buf_full, wr_accept, load, bit_end;
    logic [MAX_BITS-1:0] hold_q;
    tx_state_t           fsm_state;

    tx_hold_buf #(.MAX_BITS(MAX_BITS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .accept  (wr_accept),
        .full    (buf_full),
        .data    (hold_q)
    );

    tx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (fsm_state != ST_IDLE),
        .restart      (load),
        .baud_tick    (baud_tick),
        .double_speed (double_speed),
        .bit_end      (bit_end)
    );

    tx_frame_fsm #(.MAX_BITS(MAX_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_full   (buf_full),
        .buf_data   (hold_q),
        .bits_code  (data_bits),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .two_stop   (two_stop),
        .bit_end    (bit_end),
        .wr_accept  (wr_accept),
        .load       (load),
        .state      (fsm_state),
        .tx_line    (tx_line),
        .tx_done    (tx_done)
    );

    assign buf_empty = !buf_full;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
    import tx_pkg::*;
#(
    parameter int MAX_BITS = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_line,
    input logic                buf_empty,
    input logic                tx_done,
    input logic                load,
    input logic                bit_end,
    input logic [MAX_BITS-1:0] hold_q,
    input tx_state_t           state
);
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (buf_empty && tx_line)); // R7

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!tx_line && buf_empty)); // R6

    AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && !load) |=> $stable(hold_q)); // R10

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(bit_end && state == ST_STOP)); // R7

    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !tx_done); // R9
endmodule

bind uart_frame_tx uart_frame_tx_chk #(.MAX_BITS(MAX_BITS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_line   (tx_line),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .load      (load),
    .bit_end   (bit_end),
    .hold_q    (hold_q),
    .state     (fsm_state)
);

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/1ps
module test_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       double_speed = 1'b0;
    logic [2:0] data_bits = 3'd3;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_line, buf_empty, tx_done;

    int checks = 0;
    int errors = 0;
    int tick_count = 0;
    int div = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_frame_tx i_uart_frame_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .double_speed(double_speed),
        .data_bits(data_bits), .parity_en(parity_en), .parity_odd(parity_odd),
        .two_stop(two_stop), .wr_en(wr_en), .wr_data(wr_data),
        .tx_line(tx_line), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    // Tick source and counter of ticks seen by the design
    always @(posedge clk) begin
        div        <= (div == 2) ? 0 : div + 1;
        baud_tick  <= (div == 2);
        tick_count <= tick_count + int'(baud_tick);
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick(input int target);
        while (tick_count < target) @(negedge clk);
    endtask

    task automatic write_char(input logic [8:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic recv_frame(input int n, input bit pen, input bit podd, input int nstop,
                              input int lim, input logic [8:0] exp, input bit more);
        logic [8:0] got = '0;
        int t0, frame;
        bit p;
        do @(negedge clk); while (tx_line !== 1'b0);
        t0 = tick_count;
        wait_tick(t0 + lim / 2);
        chk(tx_line == 1'b0, "R2", "start bit", int'(tx_line), 0);
        for (int i = 0; i < n; i++) begin
            wait_tick(t0 + (i + 1) * lim + lim / 2);
            got[i] = tx_line;
        end
        chk(got == exp, "R3", "data bits lsb first", int'(got), int'(exp));
        if (pen) begin
            wait_tick(t0 + (n + 1) * lim + lim / 2);
            p = (^exp) ^ podd;
            chk(tx_line == p, "R4", "parity bit", int'(tx_line), int'(p));
        end
        for (int s = 0; s < nstop; s++) begin
            wait_tick(t0 + (n + 1 + int'(pen) + s) * lim + lim / 2);
            chk(tx_line == 1'b1, "R5", "stop bit", int'(tx_line), 1);
        end
        frame = 1 + n + int'(pen) + nstop;
        wait_tick(t0 + frame * lim - 1);
        chk(tx_line == 1'b1 && tx_done == 1'b0, "R8", "frame still in last stop",
            int'({tx_line, tx_done}), 2);
        wait_tick(t0 + frame * lim);
        if (more) begin
            chk(tx_line == 1'b0, "R9", "next start at once", int'(tx_line), 0);
            chk(tx_done == 1'b0, "R9", "done low between frames", int'(tx_done), 0);
        end else begin
            chk(tx_done == 1'b1, "R7", "done at frame end", int'(tx_done), 1);
        end
    endtask

    task automatic set_fmt(input logic [2:0] code, input bit pen, input bit podd,
                           input bit two, input bit dbl);
        @(negedge clk);
        data_bits = code; parity_en = pen; parity_odd = podd; two_stop = two; double_speed = dbl;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1", "line after reset", int'(tx_line), 1);
        chk(buf_empty == 1'b1, "R1", "buffer empty after reset", int'(buf_empty), 1);
        chk(tx_done == 1'b0, "R1", "done after reset", int'(tx_done), 0);
    endtask

    task automatic t_basic_8n1;
        set_fmt(3'd3, 0, 0, 0, 0);
        fork
            recv_frame(8, 0, 0, 1, 16, 9'h0A5, 0);
            begin
                write_char(9'h0A5);
                chk(buf_empty == 1'b0, "R6", "empty low after write", int'(buf_empty), 0);
                @(negedge clk);
                chk(buf_empty == 1'b1, "R6", "empty high at load", int'(buf_empty), 1);
                chk(tx_line == 1'b0, "R6", "start with load", int'(tx_line), 0);
            end
        join
    endtask

    task automatic t_5bit_even_2stop;
        set_fmt(3'd0, 1, 0, 1, 0);
        fork
            recv_frame(5, 1, 0, 2, 16, 9'h01B, 0);
            begin
                write_char(9'h1FB);
                chk(tx_done == 1'b0, "R7", "done cleared by write", int'(tx_done), 0);
            end
        join
    endtask

    task automatic t_9bit_odd;
        set_fmt(3'd4, 1, 1, 0, 0);
        fork
            recv_frame(9, 1, 1, 1, 16, 9'h1A3, 0);
            write_char(9'h1A3);
        join
    endtask

    task automatic t_double_7bit;
        set_fmt(3'd2, 1, 0, 0, 1);
        fork
            recv_frame(7, 1, 0, 1, 8, 9'h05A, 0);
            write_char(9'h0DA);
        join
    endtask

    task automatic t_clamped_code;
        set_fmt(3'd7, 0, 0, 0, 1);
        fork
            recv_frame(9, 0, 0, 1, 8, 9'h155, 0);
            write_char(9'h155);
        join
    endtask

    task automatic t_burst_overrun;
        set_fmt(3'd3, 0, 0, 0, 0);
        fork
            begin
                recv_frame(8, 0, 0, 1, 16, 9'h055, 1);
                recv_frame(8, 0, 0, 1, 16, 9'h00F, 0);
            end
            begin
                write_char(9'h055);
                while (buf_empty !== 1'b1) @(negedge clk);
                write_char(9'h00F);
                write_char(9'h03C);
                chk(buf_empty == 1'b0, "R10", "buffer still full after ignored write", int'(buf_empty), 0);
            end
        join
        wait_tick(tick_count + 40);
        chk(tx_line == 1'b1 && tx_done == 1'b1 && buf_empty == 1'b1, "R10",
            "no third frame after ignored write", int'({tx_line, tx_done, buf_empty}), 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_8n1();
        t_5bit_even_2stop();
        t_9bit_odd();
        t_double_7bit();
        t_clamped_code();
        t_burst_overrun();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule